// File: doc/BRIEF.md
# Fixed-Point Execution Unit with Condition Flags

This block is the integer arithmetic and logic stage of a 64-bit load/store processor core. For each operation it takes two 64-bit operands, a 16-bit immediate, and a few control flags. From these it produces a 64-bit result, a 4-bit condition field describing the result, and the next state of a small exception register. The register holds an overflow bit, a sticky summary-overflow bit and a carry bit. The register file and the instruction decoder sit outside; they present one operation at a time and raise `valid` when its effects should be committed.

Bit numbering in this note follows the convention where bit 0 is the most significant bit of a 64-bit value. In the SystemVerilog ports, that bit is index 63.

Top module: `fxu_alu`

## Requirements
- R1: After reset the three exception bits read as 0 on `ovOut`, `soOut` and `caOut` while `oe` is 0 and `opSel` is not the add-immediate operation. With `rc` at 0, `crField` reads 4'b0000.
- R2: The `opSel` encoding and its results are as follows. 0 computes A+B. 1 computes (~A)+B+1. 2 computes (~A)+1. All three are taken modulo 2^64.
- R3: When `rc` is 1, `crField[3:1]` holds the sign code of the result: 3'b100 for negative, 3'b010 for positive, 3'b001 for zero. The result is compared as a signed value against zero. With `mode64`=1 the whole 64-bit result is compared; with `mode64`=0 only `result[31:0]` is compared. When `rc` is 0, `crField` is 4'b0000.
- R4: When `oe` is 1 and the operation is add, subtract-from, negate or multiply, the overflow output equals that operation's signed overflow. `soOut` becomes the held summary bit ORed with it. Otherwise both outputs show the held values, and a set summary bit stays set.
- R5: `crField[0]` carries the new summary value. This means an overflow raised in the same operation with `oe`=1 already appears in the condition field. Without `oe`, `crField[0]` carries the held summary bit.
- R6: `opSel`=3 adds the sign-extended immediate to A, and `caOut` shows the carry out of the 64-bit sum. With `rc`=1, `crField[0]` is that addition's signed overflow instead of the summary bit. No other operation changes `caOut` from its held value.
- R7: `opSel`=4 multiplies the signed low words `opA[31:0]` and `opB[31:0]` into a signed 64-bit product. Its overflow is 1 when the product lies outside the signed 32-bit range.
- R8: `opSel`=5 computes A OR B. `opSel`=6 copies `opA[31:0]` and fills `result[63:32]` with `opA[31]`.
- R9: `opSel`=7 rotates A left by `rotAmt`. It then keeps only the top `maskEnd`+1 bits, from `result[63]` down to `result[63-maskEnd]`, and clears the rest.
- R10: The exception register loads `ovOut`, `soOut` and `caOut` on a rising clock edge only while `valid` is 1. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Commit strobe for the exception register |
| opSel | input | 3 | Operation select, encoding per R2, R6 to R9 |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B |
| imm | input | 16 | Signed immediate for add-immediate |
| oe | input | 1 | Overflow enable |
| rc | input | 1 | Record condition field |
| mode64 | input | 1 | 1 compares 64 bits for the condition, 0 compares the low word |
| rotAmt | input | 6 | Rotate-left amount |
| maskEnd | input | 6 | Last kept bit of the mask, counted from the top |
| result | output | 64 | Operation result |
| crField | output | 4 | Sign code in [3:1], summary bit in [0] |
| ovOut | output | 1 | Next overflow bit |
| soOut | output | 1 | Next summary-overflow bit |
| caOut | output | 1 | Next carry bit |

## Verification
`result`, `crField` and the three exception outputs are combinational. They are due in the same cycle as the operands. The bench therefore drives every vector on a falling edge and samples two nanoseconds later, before the next rising edge. State held in the exception register appears one rising edge after a vector with `valid` high. Checks on stickiness, holding and carry retention are placed on the vector that follows, after that edge has passed. The vector that set the state is also run once with `valid` low, to show that nothing was committed.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUBF  = 3'd1,
    OP_NEG   = 3'd2,
    OP_ADDIC = 3'd3,
    OP_MULW  = 3'd4,
    OP_OR    = 3'd5,
    OP_EXTSW = 3'd6,
    OP_ROTM  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    RS_ADD = 3'd0,
    RS_MUL = 3'd1,
    RS_OR  = 3'd2,
    RS_EXT = 3'd3,
    RS_ROT = 3'd4
  } res_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     invA;    // invert operand A into the adder
    logic     zeroB;   // force adder's second input to zero
    logic     useImm;  // second adder input is the sign-extended immediate
    logic     cin;     // adder carry-in
    res_sel_e resSel;  // result source
    logic     ovEn;    // operation defines a signed overflow for OE
    logic     caEn;    // operation writes the carry bit
    logic     ccOv;    // summary bit of the condition field is the overflow
  } strobe_t;

endpackage

// File: rtl/fxu_datapath.sv
module fxu_datapath
  import fxu_pkg::*;
#(
  parameter int DataW = 64,
  parameter int ImmW  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [DataW-1:0]           opA,
  input  logic [DataW-1:0]           opB,
  input  logic [ImmW-1:0]            imm,
  input  logic [$clog2(DataW)-1:0]   rotAmt,
  input  logic [$clog2(DataW)-1:0]   maskEnd,
  output logic [DataW-1:0]           result,
  output logic                       carryOut,
  output logic                       ovFlag
);

  localparam int HalfW = DataW / 2;
  localparam int ShW   = $clog2(DataW);

  // adder path
  logic [DataW-1:0] addX, addY, immExt;
  logic [DataW:0]   addSum;
  logic             addCarryMsbIn, addOv;

  assign immExt = {{(DataW-ImmW){imm[ImmW-1]}}, imm};

  always_comb begin
    addX = strb.invA ? ~opA : opA;
    if (strb.zeroB)       addY = '0;
    else if (strb.useImm) addY = immExt;
    else                  addY = opB;
    addSum = {1'b0, addX} + {1'b0, addY} + {{DataW{1'b0}}, strb.cin};
    addCarryMsbIn = addX[DataW-1] ^ addY[DataW-1] ^ addSum[DataW-1];
    addOv = addCarryMsbIn ^ addSum[DataW];
  end

  // multiply path: signed low words into a full-width product
  logic [DataW-1:0] mulA, mulB, mulProd;
  logic [HalfW:0]   mulTop;
  logic             mulOv;

  always_comb begin
    mulA    = {{HalfW{opA[HalfW-1]}}, opA[HalfW-1:0]};
    mulB    = {{HalfW{opB[HalfW-1]}}, opB[HalfW-1:0]};
    mulProd = mulA * mulB;
    mulTop  = mulProd[DataW-1:HalfW-1];
    mulOv   = !((&mulTop) || !(|mulTop));
  end

  // rotate-then-mask path
  logic [ShW:0]     backAmt, keepCnt;
  logic [DataW-1:0] rotVal, rotMask;

  always_comb begin
    backAmt = (ShW+1)'(DataW) - {1'b0, rotAmt};
    rotVal  = (opA << rotAmt) | (opA >> backAmt);
    keepCnt = {1'b0, maskEnd} + (ShW+1)'(1);
    rotMask = ~({DataW{1'b1}} >> keepCnt);
  end

  // result select
  always_comb begin
    unique case (strb.resSel)
      RS_MUL:  result = mulProd;
      RS_OR:   result = opA | opB;
      RS_EXT:  result = {{HalfW{opA[HalfW-1]}}, opA[HalfW-1:0]};
      RS_ROT:  result = rotVal & rotMask;
      default: result = addSum[DataW-1:0];
    endcase
    carryOut = strb.caEn & addSum[DataW];
    if (!(strb.ovEn || strb.ccOv)) ovFlag = 1'b0;
    else if (strb.resSel == RS_MUL) ovFlag = mulOv;
    else                            ovFlag = addOv;
  end

  // R8
  extsw_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resSel == RS_EXT) |-> (result[DataW-1:HalfW] == {HalfW{result[HalfW-1]}}));

  // R7
  mul_no_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resSel == RS_MUL && strb.ovEn && !ovFlag) |->
      ($countones(result[DataW-1:HalfW-1]) == 0 ||
       $countones(result[DataW-1:HalfW-1]) == HalfW + 1));

endmodule

// File: rtl/fxu_ctrl.sv
module fxu_ctrl
  import fxu_pkg::*;
#(
  parameter int DataW = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  op_e              op,
  input  logic             oe,
  input  logic             rc,
  input  logic             mode64,
  input  logic [DataW-1:0] result,
  input  logic             carryOut,
  input  logic             ovFlag,
  output strobe_t          strb,
  output logic [3:0]       crField,
  output logic             ovOut,
  output logic             soOut,
  output logic             caOut
);

  localparam int HalfW = DataW / 2;

  // decode operation into datapath strobes
  always_comb begin
    strb = '{invA: 1'b0, zeroB: 1'b0, useImm: 1'b0, cin: 1'b0,
             resSel: RS_ADD, ovEn: 1'b0, caEn: 1'b0, ccOv: 1'b0};
    unique case (op)
      OP_ADD:   strb.ovEn = 1'b1;
      OP_SUBF:  begin strb.invA = 1'b1; strb.cin = 1'b1; strb.ovEn = 1'b1; end
      OP_NEG:   begin strb.invA = 1'b1; strb.zeroB = 1'b1; strb.cin = 1'b1; strb.ovEn = 1'b1; end
      OP_ADDIC: begin strb.useImm = 1'b1; strb.caEn = 1'b1; strb.ccOv = 1'b1; end
      OP_MULW:  begin strb.resSel = RS_MUL; strb.ovEn = 1'b1; end
      OP_OR:    strb.resSel = RS_OR;
      OP_EXTSW: strb.resSel = RS_EXT;
      default:  strb.resSel = RS_ROT;
    endcase
  end

  // exception register
  logic ovQ, soQ, caQ;
  logic ovWrite;

  assign ovWrite = oe & strb.ovEn;

  always_comb begin
    ovOut = ovWrite ? ovFlag : ovQ;
    soOut = ovWrite ? (soQ | ovFlag) : soQ;
    caOut = strb.caEn ? carryOut : caQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovQ <= 1'b0;
      soQ <= 1'b0;
      caQ <= 1'b0;
    end else if (valid) begin
      ovQ <= ovOut;
      soQ <= soOut;
      caQ <= caOut;
    end
  end

  // condition field
  logic       isNeg, isZero, sumBit;
  logic [2:0] signCode;

  always_comb begin
    if (mode64) begin
      isNeg  = result[DataW-1];
      isZero = (result == '0);
    end else begin
      isNeg  = result[HalfW-1];
      isZero = (result[HalfW-1:0] == '0);
    end
    if (isNeg)       signCode = 3'b100;
    else if (isZero) signCode = 3'b001;
    else             signCode = 3'b010;
    sumBit  = strb.ccOv ? ovFlag : soOut;
    crField = rc ? {signCode, sumBit} : 4'b0000;
  end

  // R3
  cr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rc |-> $onehot(crField[3:1]));

  // R4
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    soQ |=> soQ);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable({ovQ, soQ, caQ}));

  // R6
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op != OP_ADDIC) |-> (caOut == caQ));

endmodule

// File: rtl/fxu_alu.sv
module fxu_alu
  import fxu_pkg::*;
#(
  parameter int DataW = 64,
  parameter int ImmW  = 16,
  localparam int ShW  = $clog2(DataW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic [2:0]       opSel,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [ImmW-1:0]  imm,
  input  logic             oe,
  input  logic             rc,
  input  logic             mode64,
  input  logic [ShW-1:0]   rotAmt,
  input  logic [ShW-1:0]   maskEnd,
  output logic [DataW-1:0] result,
  output logic [3:0]       crField,
  output logic             ovOut,
  output logic             soOut,
  output logic             caOut
);

  strobe_t strb;
  logic    carryOut, ovFlag;

  fxu_ctrl #(.DataW(DataW)) u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .op(op_e'(opSel)),
    .oe(oe), .rc(rc), .mode64(mode64), .result(result),
    .carryOut(carryOut), .ovFlag(ovFlag), .strb(strb),
    .crField(crField), .ovOut(ovOut), .soOut(soOut), .caOut(caOut)
  );

  fxu_datapath #(.DataW(DataW), .ImmW(ImmW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .imm(imm), .rotAmt(rotAmt), .maskEnd(maskEnd),
    .result(result), .carryOut(carryOut), .ovFlag(ovFlag)
  );

endmodule

// File: tb/fxu_alu_bench.sv
`timescale 1ns/1ps
module fxu_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [63:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic        oe = 1'b0, rc = 1'b0, mode64 = 1'b1;
  logic [5:0]  rotAmt = '0, maskEnd = '0;
  logic [63:0] result;
  logic [3:0]  crField;
  logic        ovOut, soOut, caOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fxu_alu u_fxu_alu (
    .clk(clk), .rstN(rstN), .valid(valid), .opSel(opSel), .opA(opA),
    .opB(opB), .imm(imm), .oe(oe), .rc(rc), .mode64(mode64),
    .rotAmt(rotAmt), .maskEnd(maskEnd), .result(result),
    .crField(crField), .ovOut(ovOut), .soOut(soOut), .caOut(caOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im, input logic o, input logic r, input logic m,
                       input logic [5:0] sh, input logic [5:0] me, input logic v);
    @(negedge clk);
    opSel = op; opA = a; opB = b; imm = im; oe = o; rc = r; mode64 = m;
    rotAmt = sh; maskEnd = me; valid = v;
    #2;
  endtask

  task automatic test_reset();
    chk("R1 ov", {63'd0, ovOut}, 64'd0);
    chk("R1 so", {63'd0, soOut}, 64'd0);
    chk("R1 ca", {63'd0, caOut}, 64'd0);
    chk("R1 cr", {60'd0, crField}, 64'd0);
  endtask

  task automatic test_arith();
    drive(3'd0, 64'd5, 64'd7, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R2 add", result, 64'd12);
    chk("R3 add cr pos", {60'd0, crField}, 64'h4);
    drive(3'd1, 64'd3, 64'd10, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R2 subf", result, 64'd7);
    drive(3'd1, 64'd10, 64'd3, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R2 subf neg", result, 64'hFFFF_FFFF_FFFF_FFF9);
    chk("R3 subf cr neg", {60'd0, crField}, 64'h8);
    drive(3'd2, 64'd5, 64'd99, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R2 neg", result, 64'hFFFF_FFFF_FFFF_FFFB);
  endtask

  task automatic test_mode();
    drive(3'd5, 64'h0000_0001_8000_0000, 64'd0, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R3 m64 pos", {60'd0, crField}, 64'h4);
    drive(3'd5, 64'h0000_0001_8000_0000, 64'd0, 16'd0, 0, 1, 0, 0, 0, 0);
    chk("R3 m32 neg", {60'd0, crField}, 64'h8);
    drive(3'd5, 64'h0000_0001_0000_0000, 64'd0, 16'd0, 0, 1, 0, 0, 0, 0);
    chk("R3 m32 zero", {60'd0, crField}, 64'h2);
    drive(3'd5, 64'h0000_0001_0000_0000, 64'd0, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R3 rc off", {60'd0, crField}, 64'h0);
  endtask

  task automatic test_logic();
    drive(3'd5, 64'hF0, 64'h0F, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R8 or", result, 64'hFF);
    drive(3'd6, 64'h1234_5678_8000_0001, 64'd0, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R8 extsw neg", result, 64'hFFFF_FFFF_8000_0001);
    drive(3'd6, 64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R8 extsw pos", result, 64'h0000_0000_7FFF_FFFF);
  endtask

  task automatic test_rotate();
    drive(3'd7, 64'h0123_4567_89AB_CDEF, 64'd0, 16'd0, 0, 0, 1, 6'd8, 6'd15, 0);
    chk("R9 rot8 me15", result, 64'h2345_0000_0000_0000);
    drive(3'd7, 64'h0123_4567_89AB_CDEF, 64'd0, 16'd0, 0, 0, 1, 6'd0, 6'd63, 0);
    chk("R9 rot0 full", result, 64'h0123_4567_89AB_CDEF);
    drive(3'd7, 64'h0123_4567_89AB_CDEF, 64'd0, 16'd0, 0, 0, 1, 6'd4, 6'd3, 0);
    chk("R9 rot4 me3", result, 64'h1000_0000_0000_0000);
  endtask

  task automatic test_mul();
    drive(3'd4, 64'h0000_0000_FFFF_FFFF, 64'd5, 16'd0, 1, 0, 1, 0, 0, 0);
    chk("R7 mul neg", result, 64'hFFFF_FFFF_FFFF_FFFB);
    chk("R7 mul no ov", {63'd0, ovOut}, 64'd0);
    drive(3'd4, 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000, 16'd0, 1, 0, 1, 0, 0, 0);
    chk("R7 mul big", result, 64'h0000_0001_0000_0000);
    chk("R7 mul ov", {63'd0, ovOut}, 64'd1);
    drive(3'd4, 64'hDEAD_0000_0000_0003, 64'h1234_5678_0000_0004, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R7 mul high ignored", result, 64'd12);
  endtask

  task automatic test_hold();
    drive(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1, 1, 1, 0, 0, 0);
    chk("R4 ov next", {63'd0, ovOut}, 64'd1);
    chk("R5 cr new so", {60'd0, crField}, 64'h9);
    drive(3'd0, 64'd1, 64'd1, 16'd0, 0, 1, 1, 0, 0, 0);
    chk("R10 ov not latched", {63'd0, ovOut}, 64'd0);
    chk("R10 so not latched", {63'd0, soOut}, 64'd0);
    chk("R5 cr old so", {60'd0, crField}, 64'h4);
  endtask

  task automatic test_sticky();
    drive(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1, 1, 1, 0, 0, 1);
    chk("R4 ov set", {63'd0, ovOut}, 64'd1);
    drive(3'd0, 64'd1, 64'd1, 16'd0, 0, 1, 1, 0, 0, 1);
    chk("R10 ov latched", {63'd0, ovOut}, 64'd1);
    chk("R5 cr held so", {60'd0, crField}, 64'h5);
    drive(3'd0, 64'd1, 64'd1, 16'd0, 1, 1, 1, 0, 0, 1);
    chk("R4 ov cleared", {63'd0, ovOut}, 64'd0);
    chk("R4 so sticky", {63'd0, soOut}, 64'd1);
    drive(3'd2, 64'h8000_0000_0000_0000, 64'd0, 16'd0, 1, 1, 1, 0, 0, 0);
    chk("R2 neg min", result, 64'h8000_0000_0000_0000);
    chk("R4 neg ov", {63'd0, ovOut}, 64'd1);
    chk("R5 neg cr", {60'd0, crField}, 64'h9);
    drive(3'd5, 64'd1, 64'd0, 16'd0, 1, 0, 1, 0, 0, 0);
    chk("R4 or oe ignored", {63'd0, ovOut}, 64'd0);
  endtask

  task automatic test_addic();
    drive(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, 0, 1, 1, 0, 0, 1);
    chk("R6 addic wrap", result, 64'd0);
    chk("R6 addic carry", {63'd0, caOut}, 64'd1);
    chk("R6 addic cr ov bit", {60'd0, crField}, 64'h2);
    drive(3'd5, 64'd0, 64'd0, 16'd0, 0, 0, 1, 0, 0, 0);
    chk("R6 carry held", {63'd0, caOut}, 64'd1);
    drive(3'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, 0, 1, 1, 0, 0, 0);
    chk("R6 addic ov cr", {60'd0, crField}, 64'h9);
    chk("R6 addic no carry", {63'd0, caOut}, 64'd0);
    drive(3'd3, 64'd5, 64'd0, 16'hFFFF, 0, 0, 1, 0, 0, 0);
    chk("R6 addic minus one", result, 64'd4);
    chk("R6 addic minus carry", {63'd0, caOut}, 64'd1);
    drive(3'd3, 64'd0, 64'd0, 16'h8000, 0, 0, 1, 0, 0, 0);
    chk("R6 addic sext", result, 64'hFFFF_FFFF_FFFF_8000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    test_reset();
    test_arith();
    test_mode();
    test_logic();
    test_rotate();
    test_mul();
    test_hold();
    test_sticky();
    test_addic();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule